// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Nine-Instruction Subset

This block is a 32-bit processor that fetches, decodes, executes and retires one instruction in every enabled clock cycle. It recognises nine base integer instructions: add, sub, and, or, slt, addi, lw, sw and beq. Every other encoding passes through as a no-op. The program counter, a 32-entry register file, a field decoder, the ALU and a word-addressed data memory all sit in one module. Register writes, memory writes and the program counter all update on the same rising edge.

Program memory is a small internal array. A write port loads it while reset is held. A run-enable input lets an outside stepping controller freeze every piece of state. Three observation taps show any selected register, the current program counter and the instruction being fetched. With these taps a monitor can single-step the core and inspect it between steps.

Top module: `rv_mini_core`

## Requirements
- R1: With `rst` high at a rising edge, the PC becomes 0 and all registers become 0. In each enabled cycle with no taken branch, the PC advances by 4.
- R2: Register x0 always reads as 0, and a write that targets x0 has no effect.
- R3: Opcode 0110011 with funct7/funct3 = 0000000/000 adds, 0100000/000 subtracts, 0000000/111 ANDs, 0000000/110 ORs, and 0000000/010 writes 1 to rd if rs1 < rs2 as signed values, else 0.
- R4: Opcode 0010011 with funct3 000 (addi) writes rs1 plus the sign-extended immediate from bits [31:20] into rd.
- R5: Opcode 0000011 with funct3 010 (lw) loads the word at rs1 plus the I-immediate into rd. Opcode 0100011 with funct3 010 (sw) stores rs2 at rs1 plus the sign-extended S-immediate (bits [31:25],[11:7]). The word index is address bits [N+1:2].
- R6: Opcode 1100011 with funct3 000 (beq) sets the PC to PC plus the sign-extended B-immediate when rs1 equals rs2, and otherwise to PC+4.
- R7: Any other opcode, funct3 or funct7 combination writes no register and no memory, and advances the PC by 4.
- R8: While `run_en` is low, the PC, the registers and the data memory keep their values.
- R9: `dbg_pc` shows the PC, `dbg_instr` shows the instruction at the PC, and `dbg_reg_val` shows the register chosen by `dbg_reg_sel`, all combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Lets state advance when high |
| imem_we | input | 1 | Program memory write strobe |
| imem_widx | input | IA | Program memory word index |
| imem_wdata | input | 32 | Program memory write word |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction at the current PC |

## Verification
Two things can land in the same cycle: a freeze from `run_en`, and an instruction with a side effect, such as a store or a taken loop branch. The bench drops `run_en` exactly on the cycle a store is fetched, and again for several cycles inside the counting loop. A behavioural model in the bench holds its state through those cycles. It is compared every cycle on the PC, the instruction and one rotating register. A reload of the stored word afterwards shows that the store happened once, with the right value.

// File: rtl/rv_mini_core.sv
module rv_mini_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          imem_we,
  input  logic [IA-1:0] imem_widx,
  input  logic [31:0]   imem_wdata,
  input  logic [4:0]    dbg_reg_sel,
  output logic [31:0]   dbg_reg_val,
  output logic [31:0]   dbg_pc,
  output logic [31:0]   dbg_instr
);
  localparam logic [6:0] OP_R = 7'b0110011, OP_I = 7'b0010011, OP_LD = 7'b0000011,
                         OP_ST = 7'b0100011, OP_BR = 7'b1100011;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc_q;

  wire [31:0] ins   = imem[pc_q[IA+1:2]];
  wire [6:0]  opc   = ins[6:0];
  wire [4:0]  rd    = ins[11:7];
  wire [2:0]  f3    = ins[14:12];
  wire [4:0]  rs1   = ins[19:15];
  wire [4:0]  rs2   = ins[24:20];
  wire [6:0]  f7    = ins[31:25];
  wire [31:0] a     = rf[rs1];
  wire [31:0] b     = rf[rs2];
  wire [31:0] imm_i = {{20{ins[31]}}, ins[31:20]};
  wire [31:0] imm_s = {{20{ins[31]}}, ins[31:25], ins[11:7]};
  wire [31:0] imm_b = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  alu_op_e alu_op;
  logic    reg_we, use_imm, is_load, is_store, is_beq;

  always_comb begin
    alu_op = ALU_ADD; reg_we = 1'b0; use_imm = 1'b0;
    is_load = 1'b0; is_store = 1'b0; is_beq = 1'b0;
    case (opc)
      OP_R: begin
        reg_we = 1'b1;
        case ({f7, f3})
          {7'b0000000, 3'b000}: alu_op = ALU_ADD;
          {7'b0100000, 3'b000}: alu_op = ALU_SUB;
          {7'b0000000, 3'b111}: alu_op = ALU_AND;
          {7'b0000000, 3'b110}: alu_op = ALU_OR;
          {7'b0000000, 3'b010}: alu_op = ALU_SLT;
          default:              reg_we = 1'b0;
        endcase
      end
      OP_I:  if (f3 == 3'b000) begin reg_we = 1'b1; use_imm = 1'b1; end
      OP_LD: if (f3 == 3'b010) begin reg_we = 1'b1; use_imm = 1'b1; is_load = 1'b1; end
      OP_ST: if (f3 == 3'b010) is_store = 1'b1;
      OP_BR: if (f3 == 3'b000) is_beq = 1'b1;
      default: ;
    endcase
  end

  wire [31:0] opb = is_store ? imm_s : (use_imm ? imm_i : b);
  logic [31:0] alu_y;
  always_comb begin
    case (alu_op)
      ALU_SUB: alu_y = a - opb;
      ALU_AND: alu_y = a & opb;
      ALU_OR:  alu_y = a | opb;
      ALU_SLT: alu_y = {31'd0, $signed(a) < $signed(opb)};
      default: alu_y = a + opb;
    endcase
  end

  wire [31:0] ld_data = dmem[alu_y[DA+1:2]];
  wire [31:0] wb_data = is_load ? ld_data : alu_y;
  wire        take_br = is_beq && (a == b);
  wire [31:0] pc_nx   = take_br ? pc_q + imm_b : pc_q + 32'd4;
  wire        step    = run_en && !rst;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_widx] <= imem_wdata;
    if (step && is_store) dmem[alu_y[DA+1:2]] <= b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (run_en) begin
      pc_q <= pc_nx;
      if (reg_we && rd != 5'd0) rf[rd] <= wb_data;
    end
  end

  assign dbg_reg_val = rf[dbg_reg_sel];
  assign dbg_pc      = pc_q;
  assign dbg_instr   = ins;

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(pc_q));
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !take_br) |=> pc_q == $past(pc_q) + 32'd4);
  // R6
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && is_beq && a == b) |=> pc_q == $past(pc_q + imm_b));
  // R2
  x0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0);
  // R7
  nop_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && opc == 7'b1111111 && rd == 5'd1) |=> $stable(rf[1]));
endmodule

// File: tb/rv_mini_core_test.sv
module rv_mini_core_test;
  localparam int IW = 64;
  localparam int IA = 6;
  logic clk = 0, rst = 1, run_en = 0, imem_we = 0;
  logic [IA-1:0] imem_widx = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val, dbg_pc, dbg_instr;
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  rv_mini_core #(.IMEM_WORDS(IW), .DMEM_WORDS(64)) uut (
    .clk(clk), .rst(rst), .run_en(run_en), .imem_we(imem_we), .imem_widx(imem_widx),
    .imem_wdata(imem_wdata), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_pc(dbg_pc), .dbg_instr(dbg_instr));

  logic [31:0] prog [IW];
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [int];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction
  function automatic logic [31:0] enc_s(int imm, int rs2, int rs1);
    return {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(int off, int rs2, int rs1);
    return {off[12], off[10:5], rs2[4:0], rs1[4:0], 3'b000, off[4:1], off[11], 7'b1100011};
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] ins, x, y, ea;
    int opc, f3, f7, rd, r1, r2, imm;
    ins = prog[m_pc[IA+1:2]];
    opc = int'(ins[6:0]); f3 = int'(ins[14:12]); f7 = int'(ins[31:25]);
    rd = int'(ins[11:7]); r1 = int'(ins[19:15]); r2 = int'(ins[24:20]);
    x = m_rf[r1]; y = m_rf[r2];
    imm = $signed(ins[31:20]);
    if (opc == 'h33 && f3 == 0 && f7 == 0)          m_rf[rd] = x + y;
    else if (opc == 'h33 && f3 == 0 && f7 == 'h20)  m_rf[rd] = x - y;
    else if (opc == 'h33 && f3 == 7 && f7 == 0)     m_rf[rd] = x & y;
    else if (opc == 'h33 && f3 == 6 && f7 == 0)     m_rf[rd] = x | y;
    else if (opc == 'h33 && f3 == 2 && f7 == 0)     m_rf[rd] = ($signed(x) < $signed(y)) ? 1 : 0;
    else if (opc == 'h13 && f3 == 0)                m_rf[rd] = x + imm;
    else if (opc == 'h03 && f3 == 2) begin
      ea = x + imm;
      m_rf[rd] = m_dm.exists(int'(ea[7:2])) ? m_dm[int'(ea[7:2])] : 'x;
    end else if (opc == 'h23 && f3 == 2) begin
      ea = x + 32'($signed({ins[31:25], ins[11:7]}));
      m_dm[int'(ea[7:2])] = y;
    end
    m_rf[0] = 0;
    if (opc == 'h63 && f3 == 0 && x == y)
      m_pc = m_pc + 32'($signed({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
    else m_pc = m_pc + 4;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(5, 0, 0, 1, 7'h13);
    prog[1]  = enc_i(-3, 0, 0, 2, 7'h13);
    prog[2]  = enc_r(0, 2, 1, 0, 3);
    prog[3]  = enc_r('h20, 1, 2, 0, 4);
    prog[4]  = enc_r(0, 2, 1, 7, 5);
    prog[5]  = enc_r(0, 2, 1, 6, 6);
    prog[6]  = enc_r(0, 1, 2, 2, 7);
    prog[7]  = enc_r(0, 2, 1, 2, 8);
    prog[8]  = enc_s(8, 4, 0);
    prog[9]  = enc_i(8, 0, 2, 9, 7'h03);
    prog[10] = enc_i(20, 0, 0, 11, 7'h13);
    prog[11] = enc_s(-4, 6, 11);
    prog[12] = enc_i(16, 0, 2, 12, 7'h03);
    prog[13] = enc_i(7, 0, 0, 0, 7'h13);
    prog[14] = 32'hFFFF_FFFF;
    prog[15] = enc_r(1, 1, 1, 0, 13);
    prog[16] = enc_i(1, 10, 0, 10, 7'h13);
    prog[17] = enc_b(8, 1, 10);
    prog[18] = enc_b(-8, 0, 0);
    prog[19] = enc_r(0, 5, 5, 0, 5);
    prog[20] = enc_b(0, 0, 0);

    @(negedge clk);
    for (int i = 0; i < IW; i++) begin
      imem_we = 1; imem_widx = IA'(i); imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    m_pc = 0;
    dbg_reg_sel = 5'd3; #1;
    check("R1", "reset pc", dbg_pc, 32'd0);
    check("R1", "reset reg", dbg_reg_val, 32'd0);
    rst = 0;

    for (int cyc = 0; cyc < 90; cyc++) begin
      @(negedge clk);
      run_en = !(cyc == 5 || cyc == 9 || (cyc >= 22 && cyc <= 26));
      dbg_reg_sel = 5'(cyc % 32);
      #1;
      check("R1/R6/R8", "pc", dbg_pc, m_pc);
      check("R9", "instr", dbg_instr, prog[m_pc[IA+1:2]]);
      if (cyc > 2) check("R9", "reg tap", dbg_reg_val, m_rf[cyc % 32]);
      if (run_en) model_step();
    end
    @(negedge clk);
    run_en = 0;
    #1;
    dbg_reg_sel = 0;  #1; check("R2", "x0", dbg_reg_val, 32'd0);
    dbg_reg_sel = 1;  #1; check("R4", "x1 addi", dbg_reg_val, 32'd5);
    dbg_reg_sel = 2;  #1; check("R4", "x2 addi neg", dbg_reg_val, 32'hFFFF_FFFD);
    dbg_reg_sel = 3;  #1; check("R3", "add", dbg_reg_val, 32'd2);
    dbg_reg_sel = 4;  #1; check("R3", "sub", dbg_reg_val, 32'hFFFF_FFF8);
    dbg_reg_sel = 6;  #1; check("R3", "or", dbg_reg_val, 32'hFFFF_FFFD);
    dbg_reg_sel = 7;  #1; check("R3", "slt true", dbg_reg_val, 32'd1);
    dbg_reg_sel = 8;  #1; check("R3", "slt false", dbg_reg_val, 32'd0);
    dbg_reg_sel = 5;  #1; check("R3", "and then add", dbg_reg_val, 32'd10);
    dbg_reg_sel = 9;  #1; check("R5", "lw after sw", dbg_reg_val, 32'hFFFF_FFF8);
    dbg_reg_sel = 12; #1; check("R5", "sw neg offset", dbg_reg_val, 32'hFFFF_FFFD);
    dbg_reg_sel = 10; #1; check("R6", "loop count", dbg_reg_val, 32'd5);
    dbg_reg_sel = 13; #1; check("R7", "bad funct7 no write", dbg_reg_val, 32'd0);
    check("R6", "halt pc", dbg_pc, 32'd80);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule